// File: doc/BRIEF.md
# Masked Packed Half-Precision to Int32 Converter

This block converts a vector of half-precision (FP16) floating-point lanes into signed 32-bit integers. One operation handles 4, 8 or 16 lanes, selected by a vector-length field, and fills a destination of up to 512 bits. Each lane has its own rounding unit. The rounding mode comes either from a global field or from an embedded field carried with the operation. A per-lane write mask decides which destination lanes receive new results. Lanes that are not written either keep the old destination value or are cleared.

When the source is a memory operand and the broadcast bit is set, every lane converts source element 0. When the source is a register, the operation is full length and the broadcast bit is set, the embedded rounding field takes effect instead. Values that cannot be represented as an integer (NaN and infinity) produce the integer indefinite value and raise the invalid flag. Rounded results raise the inexact flag. Both flags are sticky until reset. Results are registered, and they appear one clock after `validIn`.

Top module: `hcvt_top`

## Requirements
- R1: `vecLen` 00 selects 4 lanes (128 bits), 01 selects 8 lanes (256 bits), and 10 or 11 selects 16 lanes (512 bits). Every destination bit above the active length reads zero.
- R2: The embedded rounding field `embRound` is used only when `srcIsMem`=0, `vecLen` is 10 or 11, and `bcast`=1. In every other case `globalRound` is used.
- R3: Rounding encoding: 00 rounds to nearest with ties to even, 01 rounds toward negative infinity, 10 rounds toward positive infinity, 11 rounds toward zero. Each written lane holds the correctly rounded two's-complement integer.
- R4: A written lane whose input has a nonzero fractional part sets the sticky `inexactFlag`.
- R5: A written lane with a NaN or infinity input (exponent field all ones) returns 0x80000000 and sets the sticky `invalidFlag`.
- R6: With `srcIsMem`=1 and `bcast`=1, every written lane converts source bits [15:0]. With `srcIsMem`=0, each lane j converts its own bits [16j+15:16j].
- R7: A lane inside the active length is written when `maskEn`=0 or when its `laneMask` bit is 1. An unwritten lane with `zeroMode`=0 keeps its 32 bits from `oldDst`.
- R8: An unwritten lane inside the active length reads zero when `zeroMode`=1.
- R9: Flags are taken only from written lanes. A NaN in an unwritten lane sets no flag. Once a flag is set, it stays set until reset.
- R10: `dstOut` and the flags update on the clock edge that samples `validIn`=1. `resValid` is high for exactly that following cycle. While `validIn`=0, `dstOut` holds its value.
- R11: After reset, `dstOut`, both flags and `resValid` are zero.
- R12: Subnormals and zeros convert to 0, or to ±1 when directed rounding demands it. Negative zero gives 0. The largest finite value ±65504 converts exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operation present this cycle |
| vecLen | input | 2 | Vector length select |
| srcVec | input | 256 | Sixteen FP16 source elements, element j at bits [16j+15:16j] |
| srcIsMem | input | 1 | Source is a memory operand |
| oldDst | input | 512 | Previous destination value used for merging |
| laneMask | input | 16 | Per-lane write mask |
| maskEn | input | 1 | Apply `laneMask` |
| zeroMode | input | 1 | Clear unwritten lanes instead of merging |
| bcast | input | 1 | Broadcast / embedded-rounding bit |
| embRound | input | 2 | Embedded rounding mode |
| globalRound | input | 2 | Global rounding mode |
| dstOut | output | 512 | Registered destination |
| resValid | output | 1 | `dstOut` updated in the previous edge |
| invalidFlag | output | 1 | Sticky invalid flag |
| inexactFlag | output | 1 | Sticky inexact flag |

## Verification
The rounding tests feed exact ties (±0.5, ±1.5, 2.5), values just above and below integers, and exact integers through all four modes. This separates ties-to-even from plain rounding and shows that directed modes depend on the sign. Special inputs (NaN, ±infinity, ±65504, subnormals, ±0) show the indefinite path apart from the exact left-shift path and the tiny-value path. The broadcast, embedded-rounding, merge, zeroing and length cases each use a source whose lanes all differ and an old destination of random bits. A wrong lane selection, mode choice or clear therefore shows up as a mismatch. A seeded random sweep covers mixed settings against an integer-scaled reference model.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;
  localparam int MAX_LANES = 16;
  localparam int HALF_W    = 16;
  localparam int INT_W     = 32;
  localparam int MAX_VL    = MAX_LANES * INT_W;
  localparam int SRC_W     = MAX_LANES * HALF_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } roundMode_e;

  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_512B = 2'b11
  } vecLen_e;

  typedef struct packed {
    roundMode_e           rmode;
    logic                 bcastSel;
    logic [MAX_LANES-1:0] laneWr;
    logic [MAX_LANES-1:0] laneClr;
  } laneStrobes_t;
endpackage

// File: rtl/hcvt_lane.sv
module hcvt_lane
  import hcvt_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  input  roundMode_e        rmode,
  output logic [INT_W-1:0]  intOut,
  output logic              invalid,
  output logic              inexact
);
  localparam int EXP_W  = 5;
  localparam int MAN_W  = HALF_W - EXP_W - 1;
  localparam int SIG_W  = MAN_W + 1;
  localparam int FRAC_W = 24;
  localparam int SHIFT0 = 25;  // exponent at which the significand is an integer
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  logic                    sgn;
  logic [EXP_W-1:0]        expF;
  logic [MAN_W-1:0]        manF;
  logic [EXP_W-1:0]        effExp;
  logic [SIG_W-1:0]        sig;
  logic [SIG_W+FRAC_W-1:0] aligned;
  logic [SIG_W-1:0]        intPart;
  logic [FRAC_W-1:0]       fracPart;
  logic                    guardB, stickyB, roundUp;
  logic [INT_W-1:0]        mag;

  always_comb begin
    sgn      = halfIn[HALF_W-1];
    expF     = halfIn[HALF_W-2 -: EXP_W];
    manF     = halfIn[MAN_W-1:0];
    effExp   = (expF == '0) ? EXP_W'(1) : expF;
    sig      = {(expF != '0), manF};
    aligned  = {sig, {FRAC_W{1'b0}}} >> (SHIFT0 - int'(effExp));
    intPart  = aligned[SIG_W+FRAC_W-1:FRAC_W];
    fracPart = aligned[FRAC_W-1:0];
    guardB   = fracPart[FRAC_W-1];
    stickyB  = |fracPart[FRAC_W-2:0];
    invalid  = 1'b0;
    inexact  = 1'b0;
    roundUp  = 1'b0;
    mag      = '0;
    intOut   = '0;
    if (expF == '1) begin
      invalid = 1'b1;
      intOut  = INDEF;
    end else if (int'(effExp) >= SHIFT0) begin
      mag    = INT_W'(sig) << (int'(effExp) - SHIFT0);
      intOut = sgn ? -mag : mag;
    end else begin
      inexact = guardB | stickyB;
      unique case (rmode)
        RM_NEAR: roundUp = guardB & (stickyB | intPart[0]);
        RM_DOWN: roundUp = sgn & inexact;
        RM_UP:   roundUp = ~sgn & inexact;
        default: roundUp = 1'b0;
      endcase
      mag    = INT_W'(intPart) + INT_W'(roundUp);
      intOut = sgn ? -mag : mag;
    end
  end
endmodule

// File: rtl/hcvt_ctrl.sv
module hcvt_ctrl
  import hcvt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           vecLen,
  input  logic                 srcIsMem,
  input  logic                 bcast,
  input  logic [1:0]           embRound,
  input  logic [1:0]           globalRound,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic                 maskEn,
  input  logic                 zeroMode,
  output laneStrobes_t         strobes
);
  localparam int LANES_128 = 128 / INT_W;
  localparam int LANES_256 = 256 / INT_W;

  vecLen_e              lenSel;
  int                   laneCount;
  logic                 fullLen;
  logic [MAX_LANES-1:0] inRange;

  always_comb begin
    lenSel  = vecLen_e'(vecLen);
    fullLen = (lenSel == VL_512) || (lenSel == VL_512B);
    unique case (lenSel)
      VL_128:  laneCount = LANES_128;
      VL_256:  laneCount = LANES_256;
      default: laneCount = MAX_LANES;
    endcase
  end

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_range
    assign inRange[j] = (j < laneCount);
  end

  always_comb begin
    strobes.rmode    = (!srcIsMem && fullLen && bcast) ? roundMode_e'(embRound)
                                                       : roundMode_e'(globalRound);
    strobes.bcastSel = srcIsMem & bcast;
    strobes.laneWr   = inRange & (maskEn ? laneMask : {MAX_LANES{1'b1}});
    strobes.laneClr  = ~inRange | (~strobes.laneWr & {MAX_LANES{zeroMode}});
  end

  // R1
  short_len_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lenSel == VL_128) |-> ((strobes.laneWr >> LANES_128) == '0));

  // R7
  unmasked_all_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!maskEn && fullLen) |-> (&strobes.laneWr));
endmodule

// File: rtl/hcvt_dpath.sv
module hcvt_dpath
  import hcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [SRC_W-1:0]  srcVec,
  input  logic [MAX_VL-1:0] oldDst,
  input  laneStrobes_t      strobes,
  output logic [MAX_VL-1:0] dstOut,
  output logic              resValid,
  output logic              invalidFlag,
  output logic              inexactFlag
);
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};
  localparam int EXP_HI = HALF_W - 2;
  localparam int EXP_LO = HALF_W - 6;

  logic [MAX_VL-1:0]    merged;
  logic [MAX_LANES-1:0] laneInv, laneInx;
  logic [MAX_VL-1:0]    dstQ;
  logic                 invQ, inxQ, validQ;

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [HALF_W-1:0] laneSrc;
    logic [INT_W-1:0]  convVal;
    logic              inv, inx;
    assign laneSrc = strobes.bcastSel ? srcVec[HALF_W-1:0] : srcVec[j*HALF_W +: HALF_W];
    hcvt_lane u_lane (
      .halfIn (laneSrc),
      .rmode  (strobes.rmode),
      .intOut (convVal),
      .invalid(inv),
      .inexact(inx)
    );
    assign merged[j*INT_W +: INT_W] = strobes.laneWr[j]  ? convVal :
                                      strobes.laneClr[j] ? '0 : oldDst[j*INT_W +: INT_W];
    assign laneInv[j] = inv & strobes.laneWr[j];
    assign laneInx[j] = inx & strobes.laneWr[j];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstQ   <= '0;
      invQ   <= 1'b0;
      inxQ   <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= validIn;
      if (validIn) begin
        dstQ <= merged;
        invQ <= invQ | (|laneInv);
        inxQ <= inxQ | (|laneInx);
      end
    end
  end

  assign dstOut      = dstQ;
  assign resValid    = validQ;
  assign invalidFlag = invQ;
  assign inexactFlag = inxQ;

  // R9
  inv_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    invQ |=> invQ);

  // R5
  nan_indef_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && strobes.laneWr[0] && (srcVec[EXP_HI:EXP_LO] == '1))
      |=> (dstQ[INT_W-1:0] == INDEF) && invQ);

  // R8
  cleared_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && strobes.laneClr[MAX_LANES-1]) |=> (dstQ[MAX_VL-1 -: INT_W] == '0));

  // R7
  merge_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !strobes.laneWr[1] && !strobes.laneClr[1])
      |=> (dstQ[2*INT_W-1:INT_W] == $past(oldDst[2*INT_W-1:INT_W])));

  // R10
  hold_dst_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> $stable(dstQ));
endmodule

// File: rtl/hcvt_top.sv
module hcvt_top
  import hcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [1:0]        vecLen,
  input  logic [SRC_W-1:0]  srcVec,
  input  logic              srcIsMem,
  input  logic [MAX_VL-1:0] oldDst,
  input  logic [MAX_LANES-1:0] laneMask,
  input  logic              maskEn,
  input  logic              zeroMode,
  input  logic              bcast,
  input  logic [1:0]        embRound,
  input  logic [1:0]        globalRound,
  output logic [MAX_VL-1:0] dstOut,
  output logic              resValid,
  output logic              invalidFlag,
  output logic              inexactFlag
);
  laneStrobes_t strobes;

  hcvt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .vecLen     (vecLen),
    .srcIsMem   (srcIsMem),
    .bcast      (bcast),
    .embRound   (embRound),
    .globalRound(globalRound),
    .laneMask   (laneMask),
    .maskEn     (maskEn),
    .zeroMode   (zeroMode),
    .strobes    (strobes)
  );

  hcvt_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .validIn    (validIn),
    .srcVec     (srcVec),
    .oldDst     (oldDst),
    .strobes    (strobes),
    .dstOut     (dstOut),
    .resValid   (resValid),
    .invalidFlag(invalidFlag),
    .inexactFlag(inexactFlag)
  );
endmodule

// File: tb/hcvt_top_tb_top.sv
module hcvt_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN, validIn, srcIsMem, maskEn, zeroMode, bcast;
  logic [1:0]   vecLen, embRound, globalRound;
  logic [255:0] srcVec;
  logic [511:0] oldDst, dstOut;
  logic [15:0]  laneMask;
  logic         resValid, invalidFlag, inexactFlag;

  int nTests = 0;
  int nFail  = 0;
  logic [15:0] hv [16];
  logic expInv, expInx;
  logic [511:0] expDst;

  always #(CLK_PERIOD/2) clk = ~clk;

  hcvt_top dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .vecLen(vecLen), .srcVec(srcVec),
    .srcIsMem(srcIsMem), .oldDst(oldDst), .laneMask(laneMask), .maskEn(maskEn),
    .zeroMode(zeroMode), .bcast(bcast), .embRound(embRound), .globalRound(globalRound),
    .dstOut(dstOut), .resValid(resValid), .invalidFlag(invalidFlag), .inexactFlag(inexactFlag)
  );

  // Reference: value * 2^24 held exactly as an integer, then rounded.
  function automatic logic [33:0] refConv(logic [15:0] h, logic [1:0] rm);
    longint scaled, ip, frac;
    int     e;
    logic   inx, up;
    if (h[14:10] == 5'h1f) return {2'b10, 32'h8000_0000};
    e      = (h[14:10] == 5'd0) ? 1 : int'(h[14:10]);
    scaled = longint'({h[14:10] != 5'd0, h[9:0]}) << (e - 1);
    ip     = scaled >>> 24;
    frac   = scaled & 64'hFF_FFFF;
    inx    = (frac != 0);
    case (rm)
      2'b00:   up = (frac > 64'h80_0000) || ((frac == 64'h80_0000) && ip[0]);
      2'b01:   up = h[15] && inx;
      2'b10:   up = !h[15] && inx;
      default: up = 1'b0;
    endcase
    ip = ip + longint'(up);
    if (h[15]) ip = -ip;
    return {1'b0, inx, ip[31:0]};
  endfunction

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; validIn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expInv = 1'b0; expInx = 1'b0;
    @(negedge clk);
  endtask

  task automatic runOp(string tag, logic [1:0] vl, logic mem, logic [511:0] old,
                       logic [15:0] mask, logic mEn, logic zr, logic bc,
                       logic [1:0] emb, logic [1:0] glob);
    int nl;
    logic [1:0] rm;
    nl = (vl == 2'b00) ? 4 : (vl == 2'b01) ? 8 : 16;
    rm = (!mem && vl[1] && bc) ? emb : glob;
    expDst = '0;
    for (int j = 0; j < 16; j++) begin
      logic [33:0] r;
      if (j < nl) begin
        if (!mEn || mask[j]) begin
          r = refConv((mem && bc) ? hv[0] : hv[j], rm);
          expDst[j*32 +: 32] = r[31:0];
          expInv |= r[33];
          expInx |= r[32];
        end else if (!zr) begin
          expDst[j*32 +: 32] = old[j*32 +: 32];
        end
      end
    end
    for (int j = 0; j < 16; j++) srcVec[j*16 +: 16] = hv[j];
    vecLen = vl; srcIsMem = mem; oldDst = old; laneMask = mask; maskEn = mEn;
    zeroMode = zr; bcast = bc; embRound = emb; globalRound = glob; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    chk({tag, " dst"}, dstOut, expDst);
    chk("R9 invalid", {511'd0, invalidFlag}, {511'd0, expInv});
    chk("R4 inexact", {511'd0, inexactFlag}, {511'd0, expInx});
    chk("R10 valid", {511'd0, resValid}, 512'd1);
  endtask

  function automatic logic [511:0] rndWide();
    logic [511:0] w;
    for (int k = 0; k < 16; k++) w[k*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic tReset();
    chk("R11 dst", dstOut, '0);
    chk("R11 flags", {510'd0, invalidFlag, inexactFlag}, '0);
    chk("R11 valid", {511'd0, resValid}, '0);
  endtask

  task automatic tRound();
    logic [15:0] pat [16] = '{16'h3800, 16'h3E00, 16'h4100, 16'hB800, 16'hBE00, 16'hC100,
                              16'h3D00, 16'hC180, 16'h3C01, 16'h4500, 16'h0000, 16'h8000,
                              16'h3BFF, 16'hBBFF, 16'h4248, 16'hC248};
    for (int j = 0; j < 16; j++) hv[j] = pat[j];
    for (int m = 0; m < 4; m++) begin
      runOp("R3 round", 2'b10, 1'b0, rndWide(), 16'h0, 1'b0, 1'b0, 1'b0, 2'(~m), 2'(m));
      if (m == 0) begin
        chk("R3 tie 2.5 to even", {480'd0, dstOut[95:64]},  512'd2);
        chk("R3 tie 1.5 to even", {480'd0, dstOut[63:32]},  512'd2);
      end
      if (m == 1) chk("R3 -1.5 down", {480'd0, dstOut[159:128]}, {480'd0, 32'hFFFF_FFFE});
      if (m == 3) chk("R3 -2.75 trunc", {480'd0, dstOut[255:224]}, {480'd0, 32'hFFFF_FFFE});
    end
  endtask

  task automatic tEmbed();
    for (int j = 0; j < 16; j++) hv[j] = 16'h3E00 + 16'(j * 16'h0100);
    runOp("R2 embedded", 2'b10, 1'b0, rndWide(), 16'h0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11);
    chk("R2 1.5 up", {480'd0, dstOut[31:0]}, 512'd2);
    runOp("R2 len256 global", 2'b01, 1'b0, rndWide(), 16'h0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11);
    chk("R6 no bcast reg", {480'd0, dstOut[63:32]}, {480'd0, expDst[63:32]});
    runOp("R6 bcast mem", 2'b10, 1'b1, rndWide(), 16'h0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11);
    chk("R6 lane15 = elem0", {480'd0, dstOut[511:480]}, 512'd1);
    runOp("R6 mem no bcast", 2'b11, 1'b1, rndWide(), 16'h0, 1'b0, 1'b0, 1'b0, 2'b10, 2'b00);
  endtask

  task automatic tSpecial();
    logic [15:0] pat [16] = '{16'h7E00, 16'h7C00, 16'hFC00, 16'h7BFF, 16'hFBFF, 16'h0001,
                              16'h8001, 16'h0000, 16'h8000, 16'h03FF, 16'h0400, 16'h7C01,
                              16'h6400, 16'h3C00, 16'hBC00, 16'h5A00};
    for (int j = 0; j < 16; j++) hv[j] = pat[j];
    for (int m = 0; m < 4; m++) begin
      runOp("R12 special", 2'b10, 1'b0, rndWide(), 16'h0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(m));
      chk("R5 nan indef", {480'd0, dstOut[31:0]}, {480'd0, 32'h8000_0000});
      chk("R12 max finite", {480'd0, dstOut[127:96]}, 512'd65504);
      chk("R12 neg zero", {480'd0, dstOut[287:256]}, 512'd0);
    end
  endtask

  task automatic tMask();
    logic [511:0] old;
    doReset();
    for (int j = 0; j < 16; j++) hv[j] = 16'h4000;
    hv[0] = 16'h7E00;
    old = rndWide();
    runOp("R7 merge", 2'b10, 1'b0, old, 16'hFFFE, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
    chk("R9 masked nan no flag", {511'd0, invalidFlag}, 512'd0);
    chk("R7 lane0 kept", {480'd0, dstOut[31:0]}, {480'd0, old[31:0]});
    runOp("R8 zeroing", 2'b10, 1'b0, rndWide(), 16'h00F0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00);
    chk("R8 lane8 zero", {480'd0, dstOut[287:256]}, 512'd0);
    runOp("R9 nan written", 2'b10, 1'b0, rndWide(), 16'h0001, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
    hv[0] = 16'h4000;
    runOp("R9 sticky", 2'b10, 1'b0, rndWide(), 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00);
    chk("R9 still set", {511'd0, invalidFlag}, 512'd1);
  endtask

  task automatic tLength();
    for (int j = 0; j < 16; j++) hv[j] = 16'h4400 + 16'(j);
    runOp("R1 len128", 2'b00, 1'b0, {512{1'b1}}, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b01);
    chk("R1 upper zero 128", dstOut >> 128, '0);
    runOp("R1 len256", 2'b01, 1'b0, {512{1'b1}}, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b10);
    chk("R1 upper zero 256", dstOut >> 256, '0);
    runOp("R1 len512 alt", 2'b11, 1'b0, {512{1'b1}}, 16'h0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00);
  endtask

  task automatic tHold();
    logic [511:0] held;
    held = dstOut;
    hv[0] = 16'h7C00;
    for (int j = 0; j < 16; j++) srcVec[j*16 +: 16] = 16'h5555;
    oldDst = rndWide(); validIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 hold dst", dstOut, held);
    chk("R10 valid low", {511'd0, resValid}, 512'd0);
  endtask

  task automatic tSweep();
    for (int n = 0; n < 60; n++) begin
      for (int j = 0; j < 16; j++) hv[j] = 16'($urandom);
      runOp("R3 sweep", 2'($urandom), 1'($urandom), rndWide(), 16'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; validIn = 1'b0; vecLen = 2'b10; srcVec = '0; srcIsMem = 1'b0;
    oldDst = '0; laneMask = '0; maskEn = 1'b0; zeroMode = 1'b0; bcast = 1'b0;
    embRound = 2'b00; globalRound = 2'b00;
    doReset();
    tReset();
    tRound();
    tEmbed();
    tSpecial();
    tMask();
    tLength();
    tHold();
    tSweep();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule